// File: doc/BRIEF.md
# Single-Bit Logic and Branch Unit

This unit carries out the single-bit instructions of an 8-bit accumulator-style controller. A decoder upstream hands it a 4-bit operation code, an absolute bit address, a signed 8-bit branch offset and the address of the instruction that follows. The unit reads the selected bit through a one-cycle bit port into data memory and works out the result. Where the operation changes the bit, it writes the bit back one cycle later.

The unit owns the carry flag and exposes it so that it can be merged into a status register. The carry sits at bit address 0xD7. Any operation that names 0xD7 works on the internal flag and never reaches the memory port. The three carry-only operations (set, clear, invert carry) behave as the matching bit operations aimed at 0xD7. Conditional operations produce a one-cycle taken strobe together with the computed target.

Top module: `bitop_unit`

## Requirements
- R1: After synchronous reset, busy, carry, br_taken and mem_wr_en are all 0.
- R2: Codes 1 (set), 2 (clear) and 3 (invert) write 1, 0 or the inverted old value into the addressed memory bit. No other memory bit changes, and exactly one memory write occurs.
- R3: Codes 13, 14 and 15 set, clear and invert the carry. Any operation naming bit address 0xD7 reads and writes the carry flag in place of memory. mem_wr_en is never asserted with address 0xD7.
- R4: Code 4 branches when the bit is 1, and code 5 branches when the bit is 0. A taken branch gives a br_taken pulse one cycle wide, and br_target equals next_pc plus the sign-extended offset (modulo 2^16). An untaken branch gives no pulse. Neither code writes memory.
- R5: Code 6 branches when the bit is 1 and in that case clears the bit. When the bit is 0 it neither branches nor writes.
- R6: Code 7 copies the bit into carry without writing memory. Code 8 writes carry into the bit and leaves carry unchanged.
- R7: Codes 9, 10, 11 and 12 set carry to carry AND bit, carry AND NOT bit, carry OR bit and carry OR NOT bit, with no memory write. Code 0 changes nothing.
- R8: An operation is taken in a cycle where op_valid is high and busy is low. A read (mem_rd_en with mem_addr equal to the effective address) is issued in that same cycle, but only if the operation needs the old bit value and the address is not 0xD7. Busy is high for one cycle, or for two cycles when a memory write follows. Carry and the branch strobe update when the first busy cycle ends.
- R9: Operations offered while busy is high are ignored and leave memory and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_code | input | 4 | Operation code (0..15) |
| op_bit | input | 8 | Absolute bit address |
| op_off | input | 8 | Signed branch offset |
| op_next_pc | input | 16 | Address of the following instruction |
| busy | output | 1 | Operation in progress; new operations refused |
| mem_rd_en | output | 1 | Bit read request |
| mem_wr_en | output | 1 | Bit write strobe |
| mem_addr | output | 8 | Bit address for read or write |
| mem_wr_data | output | 1 | Bit value to write |
| mem_rd_data | input | 1 | Bit read data, valid the cycle after mem_rd_en |
| carry | output | 1 | Carry flag |
| br_taken | output | 1 | One-cycle branch-taken strobe |
| br_target | output | 16 | Branch target address |

## Verification
The hardest cases to reach from the ports are combinations of prior bit value and prior carry for every operation, including operations aimed at 0xD7, where the bit and the carry are the same storage. Before each operation under test, the bench first sets the target bit and then the carry to known values using the unit's own set and clear operations. It then sweeps all sixteen codes over both bit values, both carry values and a fixed set of edge addresses plus random addresses. While each operation is in progress, the bench holds a competing invert request on the inputs, so that any wrongly accepted operation shows up in the final full-memory comparison.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_BSET       = 4'd1,
    OP_BCLR       = 4'd2,
    OP_BINV       = 4'd3,
    OP_BR_SET     = 4'd4,
    OP_BR_CLR     = 4'd5,
    OP_BR_SET_CLR = 4'd6,
    OP_C_LOAD     = 4'd7,
    OP_C_STORE    = 4'd8,
    OP_C_AND      = 4'd9,
    OP_C_ANDN     = 4'd10,
    OP_C_OR       = 4'd11,
    OP_C_ORN      = 4'd12,
    OP_C_SET      = 4'd13,
    OP_C_CLR      = 4'd14,
    OP_C_INV      = 4'd15
  } bop_e;

  typedef enum logic [1:0] {SRC_ONE, SRC_ZERO, SRC_INV, SRC_CY} bsrc_e;
  typedef enum logic [2:0] {CY_KEEP, CY_LOAD, CY_AND, CY_ANDN, CY_OR, CY_ORN} cyop_e;
  typedef enum logic [1:0] {BR_NONE, BR_IFSET, BR_IFCLR} brc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WRITE} bst_e;

  typedef struct packed {
    logic  need_rd;
    logic  wr;
    logic  wr_if_set;
    logic  force_cy;
    bsrc_e src;
    cyop_e cy;
    brc_e  br;
  } bctl_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  bop_e  op,
  output bctl_t ctl
);
  always_comb begin
    ctl = '{need_rd: 1'b0, wr: 1'b0, wr_if_set: 1'b0, force_cy: 1'b0,
            src: SRC_ONE, cy: CY_KEEP, br: BR_NONE};
    unique case (op)
      OP_NOP:        ;
      OP_BSET:       begin ctl.wr = 1'b1; ctl.src = SRC_ONE; end
      OP_BCLR:       begin ctl.wr = 1'b1; ctl.src = SRC_ZERO; end
      OP_BINV:       begin ctl.need_rd = 1'b1; ctl.wr = 1'b1; ctl.src = SRC_INV; end
      OP_BR_SET:     begin ctl.need_rd = 1'b1; ctl.br = BR_IFSET; end
      OP_BR_CLR:     begin ctl.need_rd = 1'b1; ctl.br = BR_IFCLR; end
      OP_BR_SET_CLR: begin
        ctl.need_rd = 1'b1; ctl.br = BR_IFSET;
        ctl.wr = 1'b1; ctl.wr_if_set = 1'b1; ctl.src = SRC_ZERO;
      end
      OP_C_LOAD:     begin ctl.need_rd = 1'b1; ctl.cy = CY_LOAD; end
      OP_C_STORE:    begin ctl.wr = 1'b1; ctl.src = SRC_CY; end
      OP_C_AND:      begin ctl.need_rd = 1'b1; ctl.cy = CY_AND; end
      OP_C_ANDN:     begin ctl.need_rd = 1'b1; ctl.cy = CY_ANDN; end
      OP_C_OR:       begin ctl.need_rd = 1'b1; ctl.cy = CY_OR; end
      OP_C_ORN:      begin ctl.need_rd = 1'b1; ctl.cy = CY_ORN; end
      OP_C_SET:      begin ctl.force_cy = 1'b1; ctl.wr = 1'b1; ctl.src = SRC_ONE; end
      OP_C_CLR:      begin ctl.force_cy = 1'b1; ctl.wr = 1'b1; ctl.src = SRC_ZERO; end
      OP_C_INV:      begin
        ctl.force_cy = 1'b1; ctl.need_rd = 1'b1; ctl.wr = 1'b1; ctl.src = SRC_INV;
      end
      default:       ;
    endcase
  end
endmodule

// File: rtl/bitop_eval.sv
module bitop_eval
  import bitop_pkg::*;
(
  input  bsrc_e src,
  input  cyop_e cyop,
  input  brc_e  br,
  input  logic  wr,
  input  logic  wr_if_set,
  input  logic  bit_val,
  input  logic  cy,
  output logic  new_bit,
  output logic  new_cy,
  output logic  take,
  output logic  do_wr
);
  always_comb begin
    unique case (src)
      SRC_ONE:  new_bit = 1'b1;
      SRC_ZERO: new_bit = 1'b0;
      SRC_INV:  new_bit = ~bit_val;
      default:  new_bit = cy;
    endcase
    unique case (cyop)
      CY_LOAD: new_cy = bit_val;
      CY_AND:  new_cy = cy & bit_val;
      CY_ANDN: new_cy = cy & ~bit_val;
      CY_OR:   new_cy = cy | bit_val;
      CY_ORN:  new_cy = cy | ~bit_val;
      default: new_cy = cy;
    endcase
    unique case (br)
      BR_IFSET: take = bit_val;
      BR_IFCLR: take = ~bit_val;
      default:  take = 1'b0;
    endcase
    do_wr = wr & (~wr_if_set | bit_val);
  end
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  next_pc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);
  logic [PC_W-1:0] off_ext;
  generate
    if (PC_W > OFF_W) begin : g_sext
      assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate
  assign target = next_pc + off_ext;
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8,
  parameter int PC_W   = 16,
  parameter logic [ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] op_bit,
  input  logic [OFF_W-1:0]  op_off,
  input  logic [PC_W-1:0]   op_next_pc,
  output logic              busy,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_data,
  input  logic              mem_rd_data,
  output logic              carry,
  output logic              br_taken,
  output logic [PC_W-1:0]   br_target
);
  bst_e              st_q;
  bctl_t             ctl_in;
  logic              accept;
  logic [ADDR_W-1:0] ea_in;
  logic              alias_in;

  bsrc_e             src_q;
  cyop_e             cyop_q;
  brc_e              br_q;
  logic              wr_q, wrif_q, alias_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PC_W-1:0]   pc_q;
  logic [OFF_W-1:0]  off_q;
  logic              cy_q, wdat_q, taken_q;
  logic [PC_W-1:0]   tgt_q;

  logic              bit_val, new_bit, new_cy, take, do_wr;
  logic [PC_W-1:0]   tgt_c;

  bitop_decode u_dec (.op(bop_e'(op_code)), .ctl(ctl_in));

  assign accept   = op_valid && (st_q == ST_IDLE);
  assign ea_in    = ctl_in.force_cy ? CARRY_ADDR : op_bit;
  assign alias_in = (ea_in == CARRY_ADDR);
  assign bit_val  = alias_q ? cy_q : mem_rd_data;

  bitop_eval u_eval (
    .src(src_q), .cyop(cyop_q), .br(br_q), .wr(wr_q), .wr_if_set(wrif_q),
    .bit_val(bit_val), .cy(cy_q),
    .new_bit(new_bit), .new_cy(new_cy), .take(take), .do_wr(do_wr)
  );

  bitop_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .next_pc(pc_q), .off(off_q), .target(tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      src_q   <= SRC_ONE;
      cyop_q  <= CY_KEEP;
      br_q    <= BR_NONE;
      wr_q    <= 1'b0;
      wrif_q  <= 1'b0;
      alias_q <= 1'b0;
      addr_q  <= '0;
      pc_q    <= '0;
      off_q   <= '0;
      cy_q    <= 1'b0;
      wdat_q  <= 1'b0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
    end else begin
      taken_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          src_q   <= ctl_in.src;
          cyop_q  <= ctl_in.cy;
          br_q    <= ctl_in.br;
          wr_q    <= ctl_in.wr;
          wrif_q  <= ctl_in.wr_if_set;
          alias_q <= alias_in;
          addr_q  <= ea_in;
          pc_q    <= op_next_pc;
          off_q   <= op_off;
          st_q    <= ST_EXEC;
        end
        ST_EXEC: begin
          taken_q <= take;
          tgt_q   <= tgt_c;
          if (do_wr && alias_q) cy_q <= new_bit;
          else                  cy_q <= new_cy;
          if (do_wr && !alias_q) begin
            wdat_q <= new_bit;
            st_q   <= ST_WRITE;
          end else begin
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign mem_rd_en   = accept && ctl_in.need_rd && !alias_in;
  assign mem_wr_en   = (st_q == ST_WRITE);
  assign mem_addr    = (st_q == ST_WRITE) ? addr_q : ea_in;
  assign mem_wr_data = wdat_q;
  assign carry       = cy_q;
  assign br_taken    = taken_q;
  assign br_target   = tgt_q;

  // R3
  carry_alias_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_addr != CARRY_ADDR));
  // R8
  rd_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> busy);
  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);
  // R8
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy);
  // R4
  br_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> !br_taken);
  // R9
  no_rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> !mem_rd_en);

endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  import bitop_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [7:0]  op_bit;
  logic [7:0]  op_off;
  logic [15:0] op_next_pc;
  logic        busy, mem_rd_en, mem_wr_en, mem_wr_data, mem_rd_data;
  logic [7:0]  mem_addr;
  logic        carry, br_taken;
  logic [15:0] br_target;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;

  logic [255:0] mem;
  logic [255:0] rmem;
  logic         rcy;

  always #5 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_bit(op_bit), .op_off(op_off), .op_next_pc(op_next_pc),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
    .carry(carry), .br_taken(br_taken), .br_target(br_target)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    if (mem_wr_en) begin
      mem[mem_addr] <= mem_wr_data;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] off, input logic [15:0] pc);
    logic [7:0]  ea;
    logic        bv, nb, ncy, tk, wr, rd;
    logic [15:0] etgt;
    int          w0, cyc, ntk;
    logic [15:0] gtgt;
    ea  = (op >= 4'd13) ? 8'hD7 : a;
    bv  = (ea == 8'hD7) ? rcy : rmem[ea];
    ncy = rcy; nb = 1'b0; wr = 1'b0; tk = 1'b0; rd = 1'b0;
    case (op)
      4'd1, 4'd13: begin wr = 1; nb = 1; end
      4'd2, 4'd14: begin wr = 1; nb = 0; end
      4'd3, 4'd15: begin wr = 1; nb = ~bv; rd = 1; end
      4'd4:  begin tk = bv;  rd = 1; end
      4'd5:  begin tk = ~bv; rd = 1; end
      4'd6:  begin tk = bv; wr = bv; nb = 0; rd = 1; end
      4'd7:  begin ncy = bv; rd = 1; end
      4'd8:  begin wr = 1; nb = rcy; end
      4'd9:  begin ncy = rcy & bv;  rd = 1; end
      4'd10: begin ncy = rcy & ~bv; rd = 1; end
      4'd11: begin ncy = rcy | bv;  rd = 1; end
      4'd12: begin ncy = rcy | ~bv; rd = 1; end
      default: ;
    endcase
    if (wr) begin
      if (ea == 8'hD7) ncy = nb;
      else rmem[ea] = nb;
    end
    rcy  = ncy;
    etgt = pc + {{8{off[7]}}, off};
    op_valid = 1'b1; op_code = op; op_bit = a; op_off = off; op_next_pc = pc;
    #1;
    // R8 read request in the accepting cycle
    chk("R8", "mem_rd_en", mem_rd_en, rd && (ea != 8'hD7));
    if (rd && ea != 8'hD7) chk("R8", "mem_addr", mem_addr, ea);
    w0 = wr_count;
    @(posedge clk);
    cyc = 0; ntk = 0; gtgt = '0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (br_taken) begin ntk++; gtgt = br_target; end
      if (!busy) break;
      cyc++;
      // R9 competing request while busy
      op_valid = 1'b1; op_code = 4'd3; op_bit = 8'h30;
    end
    op_valid = 1'b0;
    chk("R8", "busy cycles", cyc, 1 + ((wr && ea != 8'hD7) ? 1 : 0));
    chk("R2", "memory writes", wr_count - w0, (wr && ea != 8'hD7) ? 1 : 0);
    chk("R7", "carry", carry, rcy);
    chk("R4", "taken pulses", ntk, tk ? 1 : 0);
    if (tk) chk("R4", "target", gtgt, etgt);
    if (ea != 8'hD7) chk("R5", "bit value", mem[ea], rmem[ea]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [0:8];
    for (int i = 0; i < 256; i++) begin
      mem[i]  = i[0] ^ i[3] ^ i[5];
      rmem[i] = i[0] ^ i[3] ^ i[5];
    end
    rcy = 1'b0;
    mem_rd_data = 1'b0;
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_bit = '0; op_off = '0; op_next_pc = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "carry", carry, 0);
    chk("R1", "br_taken", br_taken, 0);
    chk("R1", "mem_wr_en", mem_wr_en, 0);

    addrs[0] = 8'h00; addrs[1] = 8'h2F; addrs[2] = 8'hD7; addrs[3] = 8'hD0;
    addrs[4] = 8'hFF;
    for (int i = 5; i < 9; i++) addrs[i] = 8'($urandom_range(0, 255));

    // R2 R3 R4 R5 R6 R7 sweep over codes, bit values and carry values
    for (int op = 0; op < 16; op++)
      for (int bv = 0; bv < 2; bv++)
        for (int c = 0; c < 2; c++)
          for (int ai = 0; ai < 9; ai++) begin
            logic [7:0]  off;
            logic [15:0] pc;
            off = (ai == 0) ? 8'h80 : (ai == 1) ? 8'h7F : 8'($urandom);
            pc  = (ai == 4) ? 16'hFFF0 : 16'($urandom);
            run_op(bv ? 4'd1 : 4'd2, addrs[ai], 8'h00, 16'h0000);
            run_op(c ? 4'd13 : 4'd14, 8'h00, 8'h00, 16'h0000);
            run_op(4'(op), addrs[ai], off, pc);
          end

    // R9 R3 whole memory agrees with the model; 0xD7 never written
    for (int i = 0; i < 256; i++)
      chk("R9", $sformatf("mem[%0h]", i), mem[i], rmem[i]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule